// File: doc/BRIEF.md
# Buffered Dual-Edge Pulse-Width Modulator

This block generates a set of pulse-width modulated outputs from one shared time base. A prescaler divides the clock into ticks, and a counter advances once per tick. Match slot 0 holds the period, so every output repeats at the same rate. The other match slots place the output edges. Each channel can produce either a single edge, high from the start of the period until its own match, or a dual edge, set by the previous slot's match and cleared by its own. A dual-edge pulse runs positive or negative depending on which of its two values is larger.

Software writes new match values into shadow slots. A shadow value stays inactive until software sets that slot's release bit. It is then copied into the active slot only at the tick where the counter returns to zero. This means a period can never mix old and new edges. When modulation is switched off, the block runs as a plain free-running timer. In that mode, writes take effect at once and per-slot match strobes are produced.

Top module: `pwm_dual_edge`

## Requirements
- R1: After a synchronous reset, `count_val` is 0 and `pwm_out` and `match_evt` are all low.
- R2: While `run` is high, `count_val` advances once every `pre_max`+1 clock cycles. While `run` is low, `count_val` holds its value.
- R3: With `pwm_en` high, the counter counts 0, 1, … up to the active value of slot 0. On the next tick it returns to 0, so the period is slot 0 + 1 ticks.
- R4: With `pwm_en` high, a write to a slot changes no output until that slot's release bit is set. The value then takes effect at the first return to 0 after the release. The release bit clears itself at that point, and a later write needs a new release.
- R5: A channel in single-edge mode (channel k, `dbl_sel[k-1]`=0, driven by slot k) is high exactly while `count_val` < slot k. A slot value of 0 therefore gives a constant low, and a value above slot 0 gives a constant high.
- R6: A channel k ≥ 2 with `dbl_sel[k-1]`=1 goes high on the tick where the counter reaches slot k-1 and goes low on the tick where it reaches slot k. When slot k-1 is less than slot k, the pulse is positive-going. When slot k-1 is greater, the pulse is negative-going.
- R7: Channel 1 (`pwm_out[0]`) ignores `dbl_sel[0]` and always behaves as a single-edge channel.
- R8: With `pwm_en` low, the counter runs freely and wraps from all ones to 0, ignoring slot 0. Writes go straight to the active slots, and every `pwm_out` bit is held low from the cycle after `pwm_en` is seen low.
- R9: `match_evt[i]` is high for exactly the clock cycle that follows a tick on which `count_val` became equal to active slot i, in either mode.
- R10: In dual-edge mode, if both edges fall on the same count, the clear wins and the output stays low. An edge whose slot value exceeds slot 0 never fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Enables the prescaler and counter |
| pwm_en | input | 1 | 1 = modulator mode, 0 = plain timer mode |
| pre_max | input | PW | Prescaler terminal value (tick every pre_max+1 clocks) |
| wr_en | input | 1 | Match slot write strobe |
| wr_idx | input | IW | Slot index for the write |
| wr_data | input | CW | Value to write |
| rel_set | input | NM | Per-slot release strobes |
| dbl_sel | input | NM-1 | Per-channel dual-edge select (bit k-1 for channel k) |
| count_val | output | CW | Current counter value |
| pwm_out | output | NM-1 | Channel outputs, bit k-1 for channel k |
| match_evt | output | NM | Per-slot match strobes |

## Verification
The bench builds the block with an 8-bit counter, a 4-bit prescaler and four match slots, and uses a prescale of 1 so that each tick spans two clocks. The 8-bit counter makes the free-running wrap from all ones to zero reachable in a few hundred cycles, which brings the timer-mode wrap of R8 within reach. The four slots cover one single-edge-only channel and two channels that can chain dual edges. This lets the bench cover the positive-going and negative-going pulses, the coincident-edge case and out-of-range values against a cycle-level reference model.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

  typedef enum logic {
    EDGE_SINGLE = 1'b0,
    EDGE_DUAL   = 1'b1
  } edge_mode_e;

  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int PW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic [PW-1:0] pre_max,
  output logic          tick
);

  logic [PW-1:0] pc_q;

  assign tick = run && (pc_q >= pre_max);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q <= '0;
    end else if (run) begin
      if (tick) pc_q <= '0;
      else      pc_q <= pc_q + 1'b1;
    end
  end

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          pwm_en,
  input  logic [CW-1:0] period,
  output logic [CW-1:0] cnt_q,
  output logic [CW-1:0] cnt_nxt,
  output logic          wrap
);

  assign wrap = tick && pwm_en && (cnt_q == period);

  always_comb begin
    if (!tick)     cnt_nxt = cnt_q;
    else if (wrap) cnt_nxt = '0;
    else           cnt_nxt = cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_nxt;
  end

endmodule

// File: rtl/pwm_match_bank.sv
module pwm_match_bank #(
  parameter int CW = 32,
  parameter int NM = 4,
  parameter int IW = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   pwm_en,
  input  logic                   wr_en,
  input  logic [IW-1:0]          wr_idx,
  input  logic [CW-1:0]          wr_data,
  input  logic [NM-1:0]          rel_set,
  input  logic                   wrap,
  output logic [NM-1:0][CW-1:0]  act_q,
  output logic [NM-1:0][CW-1:0]  act_nxt,
  output logic [NM-1:0]          lat_q
);

  logic [NM-1:0][CW-1:0] sh_q;

  // Next active values: immediate in timer mode, released shadows at wrap.
  always_comb begin
    act_nxt = act_q;
    if (!pwm_en && wr_en) act_nxt[wr_idx] = wr_data;
    if (wrap) begin
      for (int i = 0; i < NM; i++) begin
        if (lat_q[i]) act_nxt[i] = sh_q[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q  <= '0;
      act_q <= '0;
      lat_q <= '0;
    end else begin
      if (wr_en) sh_q[wr_idx] <= wr_data;
      act_q <= act_nxt;
      lat_q <= (wrap ? '0 : lat_q) | rel_set;
    end
  end

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
  import pwm_pkg::*;
#(
  parameter int CW      = 32,
  parameter bit DUAL_OK = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pwm_en,
  input  logic          tick,
  input  logic          dbl_sel,
  input  logic [CW-1:0] cnt_nxt,
  input  logic [CW-1:0] set_val,
  input  logic [CW-1:0] clr_val,
  input  logic [CW-1:0] period,
  output logic          out_q
);

  edge_mode_e mode;
  logic       lvl_single;
  logic       set_ev;
  logic       clr_ev;
  logic       lvl_dual;

  always_comb begin
    mode       = (DUAL_OK && dbl_sel) ? EDGE_DUAL : EDGE_SINGLE;
    lvl_single = (cnt_nxt < clr_val);
    set_ev     = (cnt_nxt == set_val) && (set_val <= period);
    clr_ev     = (cnt_nxt == clr_val) && (clr_val <= period);
    if (clr_ev)      lvl_dual = 1'b0;
    else if (set_ev) lvl_dual = 1'b1;
    else             lvl_dual = out_q;
  end

  always_ff @(posedge clk) begin
    if (rst || !pwm_en) begin
      out_q <= 1'b0;
    end else if (tick) begin
      out_q <= (mode == EDGE_DUAL) ? lvl_dual : lvl_single;
    end
  end

endmodule

// File: rtl/pwm_dual_edge.sv
module pwm_dual_edge
  import pwm_pkg::*;
#(
  parameter int CW  = 32,
  parameter int PW  = 32,
  parameter int NM  = 4,
  localparam int IW  = idx_width(NM),
  localparam int NCH = NM - 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic            pwm_en,
  input  logic [PW-1:0]   pre_max,
  input  logic            wr_en,
  input  logic [IW-1:0]   wr_idx,
  input  logic [CW-1:0]   wr_data,
  input  logic [NM-1:0]   rel_set,
  input  logic [NCH-1:0]  dbl_sel,
  output logic [CW-1:0]   count_val,
  output logic [NCH-1:0]  pwm_out,
  output logic [NM-1:0]   match_evt
);

  logic                  tick_w;
  logic                  wrap_w;
  logic [CW-1:0]         cnt_nxt;
  logic [NM-1:0][CW-1:0] act_q;
  logic [NM-1:0][CW-1:0] act_nxt;
  logic [NM-1:0]         lat_q;
  logic [NM-1:0]         evt_q;

  pwm_prescaler #(.PW(PW)) u_pre (
    .clk(clk), .rst(rst), .run(run), .pre_max(pre_max), .tick(tick_w)
  );

  pwm_timebase #(.CW(CW)) u_tb (
    .clk(clk), .rst(rst), .tick(tick_w), .pwm_en(pwm_en),
    .period(act_q[0]), .cnt_q(count_val), .cnt_nxt(cnt_nxt), .wrap(wrap_w)
  );

  pwm_match_bank #(.CW(CW), .NM(NM), .IW(IW)) u_bank (
    .clk(clk), .rst(rst), .pwm_en(pwm_en), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .rel_set(rel_set), .wrap(wrap_w),
    .act_q(act_q), .act_nxt(act_nxt), .lat_q(lat_q)
  );

  for (genvar k = 1; k < NM; k++) begin : g_ch
    pwm_channel #(.CW(CW), .DUAL_OK(k >= 2)) u_ch (
      .clk(clk), .rst(rst), .pwm_en(pwm_en), .tick(tick_w),
      .dbl_sel(dbl_sel[k-1]), .cnt_nxt(cnt_nxt),
      .set_val(act_nxt[k-1]), .clr_val(act_nxt[k]), .period(act_nxt[0]),
      .out_q(pwm_out[k-1])
    );
  end

  for (genvar i = 0; i < NM; i++) begin : g_evt
    always_ff @(posedge clk) begin
      if (rst) evt_q[i] <= 1'b0;
      else     evt_q[i] <= tick_w && (cnt_nxt == act_nxt[i]);
    end
  end

  assign match_evt = evt_q;

endmodule

// File: rtl/pwm_dual_edge_chk.sv
module pwm_dual_edge_chk #(
  parameter int CW = 32,
  parameter int NM = 4,
  localparam int NCH = NM - 1
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  run,
  input logic                  pwm_en,
  input logic [NM-1:0]         rel_set,
  input logic [CW-1:0]         count_val,
  input logic [NCH-1:0]        pwm_out,
  input logic [NM-1:0]         match_evt,
  input logic                  wrap,
  input logic [NM-1:0][CW-1:0] act_q,
  input logic [NM-1:0]         lat_q
);

  AST_FREEZE_IDLE: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(!run)) |-> $stable(count_val)); // R2

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (pwm_en && $past(pwm_en) && $past(!rst) && (count_val != $past(count_val)))
      |-> (count_val == '0 || count_val == CW'($past(count_val) + 1'b1))); // R3

  AST_LATCH_SELF_CLEAR: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(wrap) && ($past(rel_set) == '0)) |-> (lat_q == '0)); // R4

  AST_TIMER_OUT_LOW: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(!pwm_en)) |-> (pwm_out == '0)); // R8

  AST_EVT_ON_MATCH: assert property (@(posedge clk) disable iff (rst)
    match_evt[0] |-> (count_val == act_q[0])); // R9

endmodule

bind pwm_dual_edge pwm_dual_edge_chk #(.CW(CW), .NM(NM)) chk_i (
  .clk(clk), .rst(rst), .run(run), .pwm_en(pwm_en), .rel_set(rel_set),
  .count_val(count_val), .pwm_out(pwm_out), .match_evt(match_evt),
  .wrap(wrap_w), .act_q(act_q), .lat_q(lat_q)
);

// File: tb/pwm_dual_edge_tb_top.sv
module pwm_dual_edge_tb_top;

  localparam int CW = 8;
  localparam int PW = 4;
  localparam int NM = 4;
  localparam int NCH = NM - 1;
  localparam int IW = 2;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG = 150000;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           run = 1'b0;
  logic           pwm_en = 1'b0;
  logic [PW-1:0]  pre_max = 4'd1;
  logic           wr_en = 1'b0;
  logic [IW-1:0]  wr_idx = '0;
  logic [CW-1:0]  wr_data = '0;
  logic [NM-1:0]  rel_set = '0;
  logic [NCH-1:0] dbl_sel = '0;
  logic [CW-1:0]  count_val;
  logic [NCH-1:0] pwm_out;
  logic [NM-1:0]  match_evt;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  string ph   = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_dual_edge #(.CW(CW), .PW(PW), .NM(NM)) dut_i (
    .clk(clk), .rst(rst), .run(run), .pwm_en(pwm_en), .pre_max(pre_max),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .rel_set(rel_set),
    .dbl_sel(dbl_sel), .count_val(count_val), .pwm_out(pwm_out),
    .match_evt(match_evt)
  );

  // ---------------- reference model -> scoreboard queue ----------------
  typedef struct {
    logic [CW-1:0]  cnt;
    logic [NCH-1:0] out;
    logic [NM-1:0]  evt;
    logic           pe;
    string          req;
  } snap_t;

  snap_t exp_q[$];

  logic [PW-1:0]  m_pc;
  logic [CW-1:0]  m_cnt, m_cn;
  logic [CW-1:0]  m_act [NM];
  logic [CW-1:0]  m_an  [NM];
  logic [CW-1:0]  m_sh  [NM];
  logic [NM-1:0]  m_lat, m_evt;
  logic [NCH-1:0] m_out;
  logic           m_tk, m_wr, m_set, m_clr;

  always @(posedge clk) begin
    snap_t s;
    if (rst) begin
      m_pc = '0; m_cnt = '0; m_lat = '0; m_evt = '0; m_out = '0;
      for (int i = 0; i < NM; i++) begin m_act[i] = '0; m_sh[i] = '0; end
    end else begin
      m_tk = run && (m_pc >= pre_max);
      if (run) m_pc = m_tk ? '0 : m_pc + 1'b1;
      m_wr = m_tk && pwm_en && (m_cnt == m_act[0]);
      for (int i = 0; i < NM; i++) m_an[i] = m_act[i];
      if (!pwm_en && wr_en) m_an[wr_idx] = wr_data;
      if (m_wr) for (int i = 0; i < NM; i++) if (m_lat[i]) m_an[i] = m_sh[i];
      if (wr_en) m_sh[wr_idx] = wr_data;
      m_lat = (m_wr ? '0 : m_lat) | rel_set;
      m_cn = !m_tk ? m_cnt : (m_wr ? '0 : m_cnt + 1'b1);
      for (int k = 1; k < NM; k++) begin
        if (!pwm_en) m_out[k-1] = 1'b0;
        else if (m_tk) begin
          if (k >= 2 && dbl_sel[k-1]) begin
            m_set = (m_cn == m_an[k-1]) && (m_an[k-1] <= m_an[0]);
            m_clr = (m_cn == m_an[k])   && (m_an[k]   <= m_an[0]);
            if (m_clr)      m_out[k-1] = 1'b0;
            else if (m_set) m_out[k-1] = 1'b1;
          end else begin
            m_out[k-1] = (m_cn < m_an[k]);
          end
        end
      end
      for (int i = 0; i < NM; i++) m_evt[i] = m_tk && (m_cn == m_an[i]);
      m_cnt = m_cn;
      for (int i = 0; i < NM; i++) m_act[i] = m_an[i];
    end
    s.cnt = m_cnt; s.out = m_out; s.evt = m_evt; s.pe = pwm_en; s.req = ph;
    exp_q.push_back(s);
  end

  // ---------------- monitor ----------------
  always @(negedge clk) begin
    snap_t e;
    cyc++;
    if (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      n_tests++;
      if (count_val !== e.cnt) begin
        n_fail++;
        $display("FAIL %s count_val: actual %0d expected %0d", e.pe ? "R3" : "R8", count_val, e.cnt);
      end
      n_tests++;
      if (pwm_out !== e.out) begin
        n_fail++;
        $display("FAIL %s pwm_out: actual %b expected %b", e.req, pwm_out, e.out);
      end
      n_tests++;
      if (match_evt !== e.evt) begin
        n_fail++;
        $display("FAIL R9 match_evt: actual %b expected %b", match_evt, e.evt);
      end
    end
    if (cyc > WDOG) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected < %0d", cyc, WDOG);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  // ---------------- driver helpers ----------------
  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr_slot(input int idx, input int val);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = IW'(idx); wr_data = CW'(val);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic release_slots(input logic [NM-1:0] m);
    @(negedge clk);
    rel_set = m;
    @(negedge clk);
    rel_set = '0;
  endtask

  task automatic wait_count(input int v);
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (count_val == CW'(v)) break;
    end
  endtask

  initial begin
    logic [CW-1:0] held;
    // R1: reset state
    idle(3);
    check("R1 count", count_val, 0);
    check("R1 pwm_out", pwm_out, 0);
    check("R1 match_evt", match_evt, 0);
    @(negedge clk); rst = 1'b0;

    // R8: timer mode, immediate writes
    ph = "R8";
    wr_slot(0, 9); wr_slot(1, 3); wr_slot(2, 6); wr_slot(3, 2);
    idle(4);
    held = count_val;
    check("R2 frozen while run low", count_val, held);
    run = 1'b1;
    idle(600);
    check("R8 outputs low in timer mode", pwm_out, 0);

    // R2: stop and hold
    run = 1'b0;
    idle(2);
    held = count_val;
    idle(10);
    check("R2 count holds with run low", count_val, held);

    // restart in modulator mode
    @(negedge clk); rst = 1'b1; pwm_en = 1'b1;
    idle(2);
    @(negedge clk); rst = 1'b0;
    ph = "R5";
    wr_slot(0, 9); wr_slot(1, 3); wr_slot(2, 0); wr_slot(3, 12);
    release_slots(4'b1111);
    run = 1'b1;
    idle(100);
    wait_count(9);
    @(negedge clk); @(negedge clk);
    check("R3 wrap to zero after period", count_val, 0);

    // R4: write without release keeps old edge
    ph = "R4";
    wr_slot(1, 7);
    idle(60);
    wait_count(5);
    check("R4 unreleased value inactive", pwm_out[0], 0);
    release_slots(4'b0010);
    idle(50);
    wait_count(5);
    check("R4 released value active", pwm_out[0], 1);
    idle(40);

    // R6: dual edges, negative (7 > 2) on ch2 and positive (2 < 5) on ch3
    ph = "R6";
    dbl_sel = 3'b110;
    wr_slot(2, 2); wr_slot(3, 5);
    release_slots(4'b1100);
    idle(100);

    // R7: channel 1 ignores dual select
    ph = "R7";
    dbl_sel = 3'b111;
    idle(60);
    wait_count(4);
    check("R7 ch1 single-edge high below slot1", pwm_out[0], 1);

    // R10: coincident edges and out-of-range set edge
    ph = "R10";
    wr_slot(1, 20); wr_slot(2, 5); wr_slot(3, 5);
    release_slots(4'b1110);
    idle(100);
    wait_count(5);
    check("R10 coincident edges stay low", pwm_out[2], 0);
    check("R10 out-of-range set never fires", pwm_out[1], 0);

    // R8: back to timer mode, outputs forced low
    ph = "R8";
    pwm_en = 1'b0;
    idle(3);
    check("R8 outputs low after mode switch", pwm_out, 0);
    idle(20);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule